// File: doc/BRIEF.md
# Quadword-to-Word Write Bridge

This block sits between a 128-bit streaming source and a 32-bit memory write port. Each beat it accepts on a valid/ready/last stream is split into four 32-bit write transactions. The writes are issued one per clock, lowest word first, to consecutive word addresses. Addresses count up from a base address set by a parameter and keep counting across beats. After the beat that carries the last flag, the count returns to the base.

Every write carries a full byte-enable mask and a fixed master identifier, so logic further down can tell which requester caused it. The block holds one beat at a time and deasserts its ready output while that beat is being emitted. A synchronous active-high reset returns it to idle.

Top module: `qw2w_bridge`

## Requirements
- R1: Every accepted beat (in_valid and in_ready high at a rising edge) produces exactly four writes, with none dropped and none duplicated. in_ready returns high only after the fourth write has been issued.
- R2: The write with index k (k = 0..3) of a beat carries bits [32k+31:32k] of that beat, so bits [31:0] go out first.
- R3: The first write after reset, or after a frame end, goes to BASE_ADDR (default 0x400). Each later write goes 4 bytes above the one before it, and this continues across beats whose last flag was 0.
- R4: Once the fourth write of a beat accepted with in_last = 1 has been issued, the next write goes to BASE_ADDR.
- R5: wr_be is 4'b1111 on every write.
- R6: wr_master equals MASTER_ID (default 8'd3) on every write.
- R7: in_ready is low from the cycle after an acceptance until the fourth write. in_valid and in_data are ignored while in_ready is low, and the held beat does not change.
- R8: At most one write is issued per clock. For a beat accepted at edge E, wr_en is high with write k in the cycle that follows edge E+1+k. Beats are written in the order they were accepted.
- R9: While rst is high at a rising edge, the block returns to idle: in_ready is 1, wr_en is 0, any partly emitted beat is dropped, and the next write address is BASE_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat valid |
| in_data | input | 128 | Input beat |
| in_last | input | 1 | Beat closes the current frame |
| in_ready | output | 1 | Bridge can accept a beat |
| wr_en | output | 1 | Write strobe, one word |
| wr_addr | output | 32 | Byte address of the word |
| wr_data | output | 32 | Word data |
| wr_be | output | 4 | Byte enables |
| wr_master | output | 8 | Master identifier of the write |

## Verification
If the word index or the busy flag goes wrong, the effect shows at the ports within a beat time. A write goes missing or is repeated, it reaches wr_en in the wrong cycle, or in_ready rises before the fourth write. The scoreboard ties every write to its expected cycle, so any of these shows up in the cycle where the write should have appeared. A bad running address shows as a wrong wr_addr on the very next write. If the address does not return to the base after a last beat, the first write of the next frame has the wrong address.

// File: rtl/qw2w_pkg.sv
package qw2w_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_EMIT = 1'b1} hold_state_t;
endpackage

// File: rtl/qw2w_beat_hold.sv
module qw2w_beat_hold
  import qw2w_pkg::*;
#(
  parameter int BEAT_W = 128,
  parameter int WORDS  = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BEAT_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              emit,
  output logic [IDX_W-1:0]  emit_idx,
  output logic [BEAT_W-1:0] beat_q,
  output logic              frame_end
);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(WORDS - 1);

  hold_state_t      state_q;
  logic [IDX_W-1:0] idx_q;
  logic             last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (in_valid) begin
          state_q <= ST_EMIT;
          idx_q   <= '0;
          last_q  <= in_last;
        end
        default: begin
          if (idx_q == IDX_MAX) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      endcase
    end
  end

  // Data path held without reset so it maps onto plain registers.
  always_ff @(posedge clk) begin
    if (state_q == ST_IDLE && in_valid) beat_q <= in_data;
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign emit      = (state_q == ST_EMIT);
  assign emit_idx  = idx_q;
  assign frame_end = emit && (idx_q == IDX_MAX) && last_q;

  // R7: held beat cannot change while it is being emitted
  a_r7_beat_held: assert property (@(posedge clk) disable iff (rst)
    emit |=> $stable(beat_q));
endmodule

// File: rtl/qw2w_addr_gen.sv
module qw2w_addr_gen #(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_0400,
  parameter int                STEP      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              emit,
  input  logic              frame_end,
  output logic [ADDR_W-1:0] addr_q
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  always_ff @(posedge clk) begin
    if (rst)            addr_q <= BASE_ADDR;
    else if (frame_end) addr_q <= BASE_ADDR;
    else if (emit)      addr_q <= addr_q + STEP_V;
  end

  // R4: address rewinds after the final word of a last beat
  a_r4_rewind: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (addr_q == BASE_ADDR));
endmodule

// File: rtl/qw2w_word_out.sv
module qw2w_word_out #(
  parameter int               BEAT_W    = 128,
  parameter int               WORD_W    = 32,
  parameter int               WORDS     = 4,
  parameter int               IDX_W     = 2,
  parameter int               ADDR_W    = 32,
  parameter int               ID_W      = 8,
  parameter logic [ID_W-1:0]  MASTER_ID = 8'd3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                emit,
  input  logic [IDX_W-1:0]    emit_idx,
  input  logic [BEAT_W-1:0]   beat_q,
  input  logic [ADDR_W-1:0]   addr_q,
  output logic                wr_en,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [WORD_W-1:0]   wr_data,
  output logic [WORD_W/8-1:0] wr_be,
  output logic [ID_W-1:0]     wr_master
);
  logic [WORD_W-1:0] words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_unpack
    assign words[g] = beat_q[g*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en     <= 1'b0;
      wr_be     <= '0;
      wr_master <= '0;
    end else begin
      wr_en     <= emit;
      wr_be     <= emit ? '1 : '0;
      wr_master <= emit ? MASTER_ID : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (emit) begin
      wr_addr <= addr_q;
      wr_data <= words[emit_idx];
    end
  end

  // R5: full byte enables on every write
  a_r5_full_be: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_be == '1));
  // R6: every write tagged with the fixed master identifier
  a_r6_master_tag: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_master == MASTER_ID));
endmodule

// File: rtl/qw2w_bridge.sv
module qw2w_bridge #(
  parameter int                BEAT_W    = 128,
  parameter int                WORD_W    = 32,
  parameter int                ADDR_W    = 32,
  parameter int                ID_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_0400,
  parameter logic [ID_W-1:0]   MASTER_ID = 8'd3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [BEAT_W-1:0]   in_data,
  input  logic                in_last,
  output logic                in_ready,
  output logic                wr_en,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [WORD_W-1:0]   wr_data,
  output logic [WORD_W/8-1:0] wr_be,
  output logic [ID_W-1:0]     wr_master
);
  localparam int WORDS = BEAT_W / WORD_W;
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int STEP  = WORD_W / 8;

  logic              emit;
  logic [IDX_W-1:0]  emit_idx;
  logic [BEAT_W-1:0] beat_q;
  logic              frame_end;
  logic [ADDR_W-1:0] addr_q;

  qw2w_beat_hold #(.BEAT_W(BEAT_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_hold (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .emit(emit),
    .emit_idx(emit_idx), .beat_q(beat_q), .frame_end(frame_end)
  );

  qw2w_addr_gen #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .STEP(STEP)) u_addr (
    .clk(clk), .rst(rst), .emit(emit), .frame_end(frame_end), .addr_q(addr_q)
  );

  qw2w_word_out #(
    .BEAT_W(BEAT_W), .WORD_W(WORD_W), .WORDS(WORDS), .IDX_W(IDX_W),
    .ADDR_W(ADDR_W), .ID_W(ID_W), .MASTER_ID(MASTER_ID)
  ) u_out (
    .clk(clk), .rst(rst), .emit(emit), .emit_idx(emit_idx),
    .beat_q(beat_q), .addr_q(addr_q), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .wr_master(wr_master)
  );

  // Checking state: emits since the last acceptance, and frame end aligned to wr_en.
  logic [IDX_W:0] emit_cnt;
  logic           fe_out_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      emit_cnt <= '0;
      fe_out_q <= 1'b0;
    end else begin
      fe_out_q <= frame_end;
      if (in_valid && in_ready) emit_cnt <= '0;
      else if (emit)            emit_cnt <= emit_cnt + 1'b1;
    end
  end

  // R1: ready comes back only after exactly WORDS emits
  a_r1_four_per_beat: assert property (@(posedge clk) disable iff (rst)
    ($rose(in_ready) && !$past(rst)) |-> (emit_cnt == (IDX_W+1)'(WORDS)));
  // R7: acceptance drops ready on the next cycle
  a_r7_ready_drop: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
  // R3: back-to-back writes within a frame step by one word
  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en) && !$past(fe_out_q)) |->
      (wr_addr == $past(wr_addr) + ADDR_W'(STEP)));
endmodule

// File: tb/qw2w_bridge_tb_top.sv
`timescale 1ns/1ps
module qw2w_bridge_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] BASE       = 32'h0000_0400;
  localparam logic [7:0]  MID        = 8'd3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] in_data = '0;
  logic         in_last = 1'b0;
  logic         in_ready;
  logic         wr_en;
  logic [31:0]  wr_addr;
  logic [31:0]  wr_data;
  logic [3:0]   wr_be;
  logic [7:0]   wr_master;

  always #(CLK_PERIOD/2) clk = ~clk;

  qw2w_bridge #(.BASE_ADDR(BASE), .MASTER_ID(MID)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .wr_master(wr_master)
  );

  typedef struct { logic [31:0] addr; logic [31:0] data; int cyc; } exp_t;
  exp_t exp_q[$];

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [31:0] exp_addr = BASE;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string msg);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // Monitor: pop and compare every write (R1 R2 R3 R4 R5 R6 R8)
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", $sformatf("unexpected write addr=%h data=%h expected none", wr_addr, wr_data));
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(wr_addr == e.addr, "R3", $sformatf("addr actual=%h expected=%h", wr_addr, e.addr));
        check(wr_data == e.data, "R2", $sformatf("data actual=%h expected=%h", wr_data, e.data));
        check(cyc == e.cyc, "R8", $sformatf("write cycle actual=%0d expected=%0d", cyc, e.cyc));
        check(wr_be == 4'hF, "R5", $sformatf("be actual=%h expected=f", wr_be));
        check(wr_master == MID, "R6", $sformatf("master actual=%0d expected=%0d", wr_master, MID));
      end
    end
  end

  // Driver: offers a beat, pushes expectations on acceptance, then drives junk.
  task automatic send_beat(input logic [127:0] d, input logic l);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = l;
    while (in_ready !== 1'b1) @(negedge clk);
    for (int j = 0; j < 4; j++) begin
      exp_t e;
      e.addr = exp_addr; e.data = d[32*j +: 32]; e.cyc = cyc + 2 + j;
      exp_q.push_back(e);
      exp_addr = exp_addr + 32'd4;
    end
    if (l) exp_addr = BASE;
    @(negedge clk);
    check(in_ready == 1'b0, "R7", $sformatf("in_ready actual=%b expected=0 after accept", in_ready));
    in_data = ~d; in_last = ~l;  // must be ignored while busy (R7)
  endtask

  task automatic go_idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && wr_en == 1'b0, "R9",
          $sformatf("reset in_ready=%b wr_en=%b expected 1/0", in_ready, wr_en));
    rst = 1'b0;
    // Frame of three back-to-back beats, junk driven while busy
    send_beat(128'hDDDD_DDDD_CCCC_CCCC_BBBB_BBBB_AAAA_AAAA, 1'b0);
    send_beat(128'h4444_4444_3333_3333_2222_2222_1111_1111, 1'b0);
    send_beat(128'h0F0E0D0C_0B0A0908_07060504_03020100, 1'b1);
    // R4: next frame starts at base again, after a gap
    go_idle(3);
    check(in_ready == 1'b1, "R1", $sformatf("in_ready actual=%b expected=1 when idle", in_ready));
    send_beat(128'h8000_0001_4000_0002_2000_0004_1000_0008, 1'b1);
    send_beat(128'hFFFF_FFFF_0000_0000_FFFF_FFFF_0000_0000, 1'b0);
    go_idle(6);
    check(exp_q.size() == 0, "R1", $sformatf("pending writes actual=%0d expected=0", exp_q.size()));
    // R9: reset in mid-emission drops the beat and rewinds the address
    send_beat(128'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321, 1'b0);
    @(negedge clk);
    #1 rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    check(wr_en == 1'b0 && in_ready == 1'b1, "R9",
          $sformatf("after reset wr_en=%b in_ready=%b expected 0/1", wr_en, in_ready));
    exp_q.delete();
    exp_addr = BASE;
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(wr_en == 1'b0, "R9", $sformatf("wr_en actual=%b expected=0 after dropped beat", wr_en));
    send_beat(128'hCAFE_0003_CAFE_0002_CAFE_0001_CAFE_0000, 1'b1);
    go_idle(6);
    check(exp_q.size() == 0, "R1", $sformatf("pending writes actual=%0d expected=0", exp_q.size()));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R1: watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule